// File: doc/BRIEF.md
# Four-Channel Down-Counter Timer Unit

This block is a register-mapped timer with four independent down-counters. A single-cycle register port reads and writes them, and one interrupt line serves all four. Each channel has four registers: a start value, a live count, a control byte and a reload value. Writing the start value restarts the count at once. Writing the reload value changes only the count that is picked up at the next wrap, so a period can be retuned without disturbing the cycle already in progress.

The control byte selects the behaviour of its channel. A channel can run free and wrap to all ones, reload from its reload value (periodic), or stop at zero (one-shot). It also picks an input divider of 1, 16 or 256 and a 16-bit or 32-bit counter. A channel flags an event on the tick that takes its count from 1 to 0. The shared interrupt set keeps one pending bit per channel, a per-channel enable mask and a write-one-to-clear register. The output line is high while any enabled channel has a pending bit.

Top module: `tmr4_unit`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Channel n uses the byte offsets 0x10+0x10*n (start value), +0x4 (live count), +0x8 (control) and +0xC (reload value). A start-value write copies the data into the live count and the reload value on the same edge, and the start register reads back the written word. Writes to the live-count offset are ignored.
- R3: Control bits 3:2 select the count divider: 00 counts on every clock, 01 on every 16th clock and 10 or 11 on every 256th clock. Writing the control register restarts the divider, so the first tick comes that many clocks after the write.
- R4: While control bit 7 is set, each tick lowers the count by one. While bit 7 is clear the count holds.
- R5: A tick that takes the count from 1 to 0 sets that channel's pending bit (bit n of offset 0x04). A start-value write in the same cycle takes precedence: it suppresses both the decrement and the event.
- R6: With control bit 0 set, the count stops at 0 and holds there until a new start value is written. This holds whatever the value of bit 6.
- R7: With bits 0 and 6 both clear, a tick at 0 wraps the count to all ones across the selected width (0xFFFF or 0xFFFFFFFF).
- R8: With bit 6 set and bit 0 clear, a tick at 0 loads the reload value. A reload-value write does not change the live count.
- R9: With control bit 1 clear, the counter uses its low 16 bits only and the live count reads zero in bits 31:16. With bit 1 set it uses all 32 bits.
- R10: Writing 1 to bit n of offset 0x0C clears pending bit n, and writing 0 leaves it unchanged. If a new event arrives in the same cycle as the clear, the bit stays set.
- R11: Offset 0x00 holds the per-channel enable mask. Offset 0x08 reads pending AND mask, and `irq` is the OR of those bits, so a zero mask keeps `irq` low.
- R12: Reads from misaligned or unmapped offsets (including 0x0C and anything at or above 0x50) return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the current address |
| reg_addr | input | ADDR_W (8) | Byte address of the access |
| reg_wdata | input | CNT_W (32) | Write data |
| reg_rdata | output | CNT_W (32) | Read data for `reg_addr`, combinational |
| irq | output | 1 | OR of all masked pending bits |

## Verification
The risky collision is a channel's 1-to-0 event landing in the same cycle as a write-one clear of that channel's pending bit. The other collision is a start-value write in the same cycle as a tick that would have produced an event. The bench counts clocks from the control write so that the clear write falls exactly on the event cycle. It then reads the pending register and expects the bit to remain set. A behavioural model, stepped every clock and compared on every read, judges all other cycles, including the load-versus-tick case.

// File: rtl/tmr4_pkg.sv
package tmr4_pkg;

  localparam int CNT_W    = 32;
  localparam int NARROW_W = 16;
  localparam int CTRL_W   = 8;
  localparam int PSC_W    = 8;

  // control byte bit positions
  localparam int CB_RUN    = 7;
  localparam int CB_REPEAT = 6;
  localparam int CB_DIV_HI = 3;
  localparam int CB_DIV_LO = 2;
  localparam int CB_WIDE   = 1;
  localparam int CB_SINGLE = 0;

  typedef enum logic [1:0] {
    DIV_BY_1   = 2'b00,
    DIV_BY_16  = 2'b01,
    DIV_BY_256 = 2'b10,
    DIV_SPARE  = 2'b11
  } div_sel_e;

  // true on the clock where the divider hands out a count tick
  function automatic logic div_due(input div_sel_e sel, input logic [PSC_W-1:0] cnt);
    case (sel)
      DIV_BY_1:  return 1'b1;
      DIV_BY_16: return cnt[3:0] == 4'hF;
      default:   return cnt == {PSC_W{1'b1}};
    endcase
  endfunction

  // value the counter takes on a tick, from its width-masked current value
  function automatic logic [CNT_W-1:0] next_count(
    input logic [CNT_W-1:0] eff,
    input logic [CNT_W-1:0] wmask,
    input logic [CNT_W-1:0] reload,
    input logic             single,
    input logic             repeat_on
  );
    if (eff != '0)     return eff - 1'b1;
    else if (single)   return eff;
    else if (repeat_on) return reload & wmask;
    else               return wmask;
  endfunction

endpackage

// File: rtl/tmr4_prescale.sv
module tmr4_prescale
  import tmr4_pkg::*;
#(
  parameter int PW = PSC_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] sel,
  output logic       tick
);
  logic [PW-1:0] pcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pcnt_q <= '0;
    else if (!run || restart)  pcnt_q <= '0;
    else                       pcnt_q <= pcnt_q + 1'b1;
  end

  assign tick = run && div_due(div_sel_e'(sel), pcnt_q);

endmodule

// File: rtl/tmr4_channel.sv
module tmr4_channel
  import tmr4_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int NW = NARROW_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_start,
  input  logic          wr_reload,
  input  logic          wr_ctrl,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rd_start,
  output logic [CW-1:0] rd_count,
  output logic [CTRL_W-1:0] rd_ctrl,
  output logic [CW-1:0] rd_reload,
  output logic          event_o
);
  localparam logic [CW-1:0] NARROW_MASK = {{(CW-NW){1'b0}}, {NW{1'b1}}};
  localparam logic [CW-1:0] ONE         = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0]     start_q, reload_q, cnt_q;
  logic [CTRL_W-1:0] ctrl_q;

  logic          run, wide, single, repeat_on, tick, cur_zero;
  logic [1:0]    sel;
  logic [CW-1:0] wmask, eff;

  assign run       = ctrl_q[CB_RUN];
  assign repeat_on = ctrl_q[CB_REPEAT];
  assign sel       = ctrl_q[CB_DIV_HI:CB_DIV_LO];
  assign wide      = ctrl_q[CB_WIDE];
  assign single    = ctrl_q[CB_SINGLE];
  assign wmask     = wide ? '1 : NARROW_MASK;
  assign eff       = cnt_q & wmask;
  assign cur_zero  = (eff == '0);

  tmr4_prescale u_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .restart (wr_ctrl),
    .sel     (sel),
    .tick    (tick)
  );

  // named event: the 1 -> 0 step, cancelled by a start write
  assign event_o = tick && (eff == ONE) && !wr_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q  <= '0;
      reload_q <= '0;
      cnt_q    <= '0;
      ctrl_q   <= '0;
    end else begin
      if (wr_start) begin
        start_q  <= wdata;
        reload_q <= wdata;
        cnt_q    <= wdata;
      end else begin
        if (tick)      cnt_q    <= next_count(eff, wmask, reload_q, single, repeat_on);
        if (wr_reload) reload_q <= wdata;
      end
      if (wr_ctrl) ctrl_q <= wdata[CTRL_W-1:0];
    end
  end

  assign rd_start  = start_q;
  assign rd_count  = eff;
  assign rd_ctrl   = ctrl_q;
  assign rd_reload = reload_q;

  // R4: a tick on a nonzero count lowers it by exactly one
  p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_start && !wr_ctrl && !cur_zero) |=> (rd_count == $past(eff) - 1'b1));

  // R6: a one-shot channel sitting at zero stays at zero
  p_oneshot_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && single && cur_zero && !wr_start && !wr_ctrl) |=> (rd_count == '0));

endmodule

// File: rtl/tmr4_irq.sv
module tmr4_irq #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev,
  input  logic         mask_wr,
  input  logic         clr_wr,
  input  logic [N-1:0] wbits,
  output logic [N-1:0] mask_q,
  output logic [N-1:0] raw_q,
  output logic [N-1:0] masked,
  output logic         irq
);
  logic [N-1:0] clr_bits;

  assign clr_bits = clr_wr ? wbits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      raw_q  <= '0;
    end else begin
      raw_q <= (raw_q & ~clr_bits) | ev;
      if (mask_wr) mask_q <= wbits;
    end
  end

  assign masked = raw_q & mask_q;
  assign irq    = |masked;

  // R5: every channel event leaves its pending bit set
  p_event_sets_raw_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != '0) |=> ((raw_q & $past(ev)) == $past(ev)));

  // R10: a clear without a coinciding event empties the bit
  p_clear_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((raw_q & $past(wbits & ~ev)) == '0));

endmodule

// File: rtl/tmr4_unit.sv
module tmr4_unit
  import tmr4_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CW     = CNT_W,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CW-1:0]     reg_wdata,
  output logic [CW-1:0]     reg_rdata,
  output logic              irq
);
  localparam int WORD_W  = ADDR_W - 2;
  localparam int CH_BASE = 4;   // first channel word (byte 0x10)
  localparam int CH_SPAN = 4;   // words per channel

  localparam logic [WORD_W-1:0] W_MASK  = WORD_W'(0);
  localparam logic [WORD_W-1:0] W_RAW   = WORD_W'(1);
  localparam logic [WORD_W-1:0] W_MSKD  = WORD_W'(2);
  localparam logic [WORD_W-1:0] W_CLEAR = WORD_W'(3);

  logic              aligned, wr_ok;
  logic [WORD_W-1:0] word;

  assign aligned = (reg_addr[1:0] == 2'b00);
  assign word    = reg_addr[ADDR_W-1:2];
  assign wr_ok   = reg_wr && aligned;

  logic [NUM_CH-1:0] ch_event, mask_q, raw_q, masked;
  logic [CW-1:0]     rd_start  [NUM_CH];
  logic [CW-1:0]     rd_count  [NUM_CH];
  logic [CW-1:0]     rd_reload [NUM_CH];
  logic [CTRL_W-1:0] rd_ctrl   [NUM_CH];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam logic [WORD_W-1:0] BASE = WORD_W'(CH_BASE + CH_SPAN * i);
    tmr4_channel #(.CW(CW)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_start  (wr_ok && word == BASE),
      .wr_reload (wr_ok && word == BASE + WORD_W'(3)),
      .wr_ctrl   (wr_ok && word == BASE + WORD_W'(2)),
      .wdata     (reg_wdata),
      .rd_start  (rd_start[i]),
      .rd_count  (rd_count[i]),
      .rd_ctrl   (rd_ctrl[i]),
      .rd_reload (rd_reload[i]),
      .event_o   (ch_event[i])
    );
  end

  tmr4_irq #(.N(NUM_CH)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev      (ch_event),
    .mask_wr (wr_ok && word == W_MASK),
    .clr_wr  (wr_ok && word == W_CLEAR),
    .wbits   (reg_wdata[NUM_CH-1:0]),
    .mask_q  (mask_q),
    .raw_q   (raw_q),
    .masked  (masked),
    .irq     (irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (aligned) begin
      if (word == W_MASK) reg_rdata = {{(CW-NUM_CH){1'b0}}, mask_q};
      if (word == W_RAW)  reg_rdata = {{(CW-NUM_CH){1'b0}}, raw_q};
      if (word == W_MSKD) reg_rdata = {{(CW-NUM_CH){1'b0}}, masked};
      for (int i = 0; i < NUM_CH; i++) begin
        if (word == WORD_W'(CH_BASE + CH_SPAN * i))     reg_rdata = rd_start[i];
        if (word == WORD_W'(CH_BASE + CH_SPAN * i + 1)) reg_rdata = rd_count[i];
        if (word == WORD_W'(CH_BASE + CH_SPAN * i + 2)) reg_rdata = {{(CW-CTRL_W){1'b0}}, rd_ctrl[i]};
        if (word == WORD_W'(CH_BASE + CH_SPAN * i + 3)) reg_rdata = rd_reload[i];
      end
    end
  end

endmodule

// File: tb/tb_tmr4_unit.sv
`timescale 1ns/1ps
module tb_tmr4_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  always #4 clk = ~clk;

  tmr4_unit dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  int errors = 0;
  int checks = 0;
  string phase = "R1";
  logic [31:0] last_rd;

  // behavioural reference
  logic [31:0] m_start [4];
  logic [31:0] m_cnt   [4];
  logic [31:0] m_rel   [4];
  logic [7:0]  m_ctl   [4];
  int          m_pc    [4];
  logic [3:0]  m_raw, m_mask;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] wm_of(input logic [7:0] c);
    return c[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endfunction

  function automatic int div_of(input logic [7:0] c);
    case (c[3:2]) 2'b00: return 1; 2'b01: return 16; default: return 256; endcase
  endfunction

  function automatic logic [31:0] m_read(input int a);
    if (a % 4 != 0) return 0;
    if (a == 0) return {28'd0, m_mask};
    if (a == 4) return {28'd0, m_raw};
    if (a == 8) return {28'd0, m_raw & m_mask};
    if (a >= 16 && a < 80) begin
      int ch = (a - 16) / 16;
      case (((a - 16) % 16) / 4)
        0: return m_start[ch];
        1: return m_cnt[ch] & wm_of(m_ctl[ch]);
        2: return {24'd0, m_ctl[ch]};
        default: return m_rel[ch];
      endcase
    end
    return 0;
  endfunction

  task automatic m_step(input bit w, input int a, input logic [31:0] d);
    logic [3:0] ev = '0;
    logic [3:0] clr = '0;
    bit al = (a % 4 == 0);
    for (int ch = 0; ch < 4; ch++) begin
      bit ld  = w && al && a == 16 + 16 * ch;
      bit cw  = w && al && a == 24 + 16 * ch;
      bit rw  = w && al && a == 28 + 16 * ch;
      bit en  = m_ctl[ch][7];
      int dv  = div_of(m_ctl[ch]);
      bit tk  = en && (m_pc[ch] == dv - 1);
      logic [31:0] wm  = wm_of(m_ctl[ch]);
      logic [31:0] eff = m_cnt[ch] & wm;
      if (ld) begin
        m_cnt[ch] = d; m_rel[ch] = d; m_start[ch] = d;
      end else if (tk) begin
        if (eff == 1) ev[ch] = 1'b1;
        if (eff != 0)            m_cnt[ch] = eff - 1;
        else if (m_ctl[ch][0])   m_cnt[ch] = eff;
        else if (m_ctl[ch][6])   m_cnt[ch] = m_rel[ch] & wm;
        else                     m_cnt[ch] = wm;
      end
      if (rw) m_rel[ch] = d;
      if (cw || !en) m_pc[ch] = 0; else m_pc[ch] = (m_pc[ch] + 1) % dv;
      if (cw) m_ctl[ch] = d[7:0];
    end
    if (w && a == 12) clr = d[3:0];
    if (w && a == 0)  m_mask = d[3:0];
    m_raw = (m_raw & ~clr) | ev;
  endtask

  // one bus cycle: compare against the model, then advance both
  task automatic cyc(input bit w, input int a, input logic [31:0] d);
    reg_wr = w; reg_addr = a[7:0]; reg_wdata = d;
    #1;
    last_rd = reg_rdata;
    chk({phase, " rdata"}, reg_rdata, m_read(a));
    chk({phase, " irq R11"}, {31'd0, irq}, {31'd0, |(m_raw & m_mask)});
    m_step(w, a, d);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input int a); cyc(1'b0, a, 32'h0); endtask
  task automatic wr(input int a, input logic [31:0] d); cyc(1'b1, a, d); endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      m_start[i] = 0; m_cnt[i] = 0; m_rel[i] = 0; m_ctl[i] = 0; m_pc[i] = 0;
    end
    m_raw = 0; m_mask = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: all registers zero after reset
    phase = "R1";
    for (int a = 0; a < 96; a += 4) begin
      rd(a);
      chk("R1 reset read", last_rd, 32'h0);
    end
    chk("R1 irq low", {31'd0, irq}, 32'h0);

    // R2: start write fills count and reload; count offset ignores writes
    phase = "R2";
    wr(16'h30, 32'h1234);
    rd(16'h30); chk("R2 start readback", last_rd, 32'h1234);
    rd(16'h3C); chk("R2 reload copy", last_rd, 32'h1234);
    wr(16'h34, 32'h55);
    rd(16'h34); chk("R2 count write ignored", last_rd, 32'h1234);

    // R9: narrow width hides the upper half
    phase = "R9";
    wr(16'h30, 32'h0001_2345);
    rd(16'h34); chk("R9 narrow count", last_rd, 32'h0000_2345);

    // R12: misaligned and unmapped
    phase = "R12";
    wr(16'h50, 32'hFFFF_FFFF);
    wr(16'h11, 32'hABCD);
    rd(16'h50); chk("R12 unmapped read", last_rd, 32'h0);
    rd(16'h12); chk("R12 misaligned read", last_rd, 32'h0);
    rd(16'h10); chk("R12 misaligned write ignored", last_rd, 32'h0);
    rd(16'h0C); chk("R12 clear reads zero", last_rd, 32'h0);

    // R7 with R4 and R5: narrow free-running wrap on channel 0
    phase = "R7";
    wr(16'h00, 32'hF);
    wr(16'h10, 32'h1);
    wr(16'h18, 32'h80);
    rd(16'h14); chk("R4 count before tick", last_rd, 32'h1);
    rd(16'h14); chk("R4 count reached zero", last_rd, 32'h0);
    rd(16'h14); chk("R7 narrow wrap", last_rd, 32'h0000_FFFF);
    rd(16'h04); chk("R5 pending set", last_rd & 32'h1, 32'h1);
    wr(16'h18, 32'h00);
    // R7 wide wrap on channel 1
    wr(16'h20, 32'h1);
    wr(16'h28, 32'h82);
    rd(16'h24); rd(16'h24);
    rd(16'h24); chk("R7 wide wrap", last_rd, 32'hFFFF_FFFF);
    wr(16'h28, 32'h00);

    // R6: one-shot with periodic bit also set
    phase = "R6";
    wr(16'h20, 32'h2);
    wr(16'h28, 32'hC3);
    for (int i = 0; i < 10; i++) rd(16'h24);
    chk("R6 one-shot holds zero", last_rd, 32'h0);

    // R10: event and clear in the same cycle, set wins
    phase = "R10";
    wr(16'h40, 32'h2);
    wr(16'h48, 32'h80);
    rd(16'h44);                 // tick 2 -> 1
    wr(16'h0C, 32'h8);          // tick 1 -> 0 with clear
    rd(16'h04); chk("R10 set wins over clear", last_rd & 32'h8, 32'h8);
    chk("R11 irq high", {31'd0, irq}, 32'h1);
    wr(16'h0C, 32'h8);
    rd(16'h04); chk("R10 clear empties bit", last_rd & 32'h8, 32'h0);
    wr(16'h48, 32'h00);

    // R5: start write on the event cycle cancels the event
    phase = "R5";
    wr(16'h40, 32'h2);
    wr(16'h48, 32'h80);
    rd(16'h44);
    wr(16'h40, 32'h9);
    rd(16'h04); chk("R5 load cancels event", last_rd & 32'h8, 32'h0);
    wr(16'h48, 32'h00);

    // R8: periodic reload, reload write leaves count alone
    phase = "R8";
    wr(16'h30, 32'h3);
    wr(16'h38, 32'hC0);
    wr(16'h3C, 32'h7);
    rd(16'h34); chk("R8 reload write leaves count", last_rd, 32'h2);
    rd(16'h34); rd(16'h34);
    rd(16'h34); chk("R8 reload at wrap", last_rd, 32'h7);
    for (int i = 0; i < 20; i++) rd(16'h34);
    wr(16'h38, 32'h00);

    // R3: dividers 16 and 256
    phase = "R3";
    wr(16'h10, 32'd10);
    wr(16'h18, 32'h84);
    for (int i = 0; i < 16; i++) rd(16'h14);
    rd(16'h14); chk("R3 div16 first tick", last_rd, 32'd9);
    for (int i = 0; i < 40; i++) rd(16'h14);
    wr(16'h10, 32'd5);
    wr(16'h18, 32'h88);
    for (int i = 0; i < 256; i++) rd(16'h14);
    rd(16'h14); chk("R3 div256 first tick", last_rd, 32'd4);
    wr(16'h18, 32'h8C);
    for (int i = 0; i < 300; i++) rd(16'h14);
    wr(16'h18, 32'h00);
    rd(16'h14);
    for (int i = 0; i < 5; i++) rd(16'h14);
    chk("R4 disabled holds", last_rd, m_read(16'h14));

    // R11: zero mask silences the line
    phase = "R11";
    wr(16'h00, 32'h0);
    rd(16'h08); chk("R11 masked zero", last_rd, 32'h0);
    chk("R11 irq quiet", {31'd0, irq}, 32'h0);
    wr(16'h00, 32'h1);
    rd(16'h08); chk("R11 masked follows raw", last_rd, {28'd0, m_raw & 4'h1});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule